// File: doc/BRIEF.md
# Pipelined Memory Read Controller

This block wraps a 256-word by 32-bit storage bank and runs its reads as a two-stage pipeline. Each read is split across two clock edges. On the first edge the address is latched and decoded, and the wordline strobe goes high for one cycle. On the next rising edge the sense strobe fires and the addressed word is captured. Because the two stages overlap, a new read can be accepted on every cycle, while each read still takes two cycles to return its data.

Two options help bring up the block at different operating points. The first is a small extra delay setting of zero to three cycles. It lengthens the return path so the memory timing can follow the clock frequency. The second is a bypass mode. In this mode a single 32-bit holding register stands in for the array, so the surrounding data path keeps working even when the array is suspect. In this project the array itself is a behavioural register model.

Top module: `pipe_sram_rd`

## Requirements
- R1: While reset is asserted, and after it is released, rd_valid, wl_en and sa_en are low. The bypass holding register starts at zero, so a bypass read issued before any bypass write returns 32'h0.
- R2: wl_en is high in the cycle after a cycle in which rd_en was high. sa_en is high exactly one cycle after wl_en.
- R3: With extra delay D = dly_cfg (0 to 3), rd_valid is high exactly in cycle c+2+D, where c is the cycle in which rd_en was high. In that cycle rd_data carries the requested word. dly_cfg must stay constant while reads are in flight.
- R4: Reads may be issued in every consecutive cycle. Each read returns its own word, in issue order, one result per cycle.
- R5: With bypass_en low, a write stores wr_data at addr on the clock edge. A read issued in the same cycle as a write, or in any later cycle, returns the newly written word.
- R6: A write issued in the cycle after a read of the same address does not change the word that read returns.
- R7: A write with bypass_en high loads the bypass register and leaves the array unchanged.
- R8: A read with bypass_en high in its issue cycle returns the bypass register contents, with the same latency as an array read. Bypass and array reads may be interleaved back to back.
- R9: All 256 addresses (addr is 8 bits) hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Issue a read of addr this cycle |
| wr_en | input | 1 | Write wr_data this cycle |
| addr | input | 8 | Word address for reads and writes |
| wr_data | input | 32 | Write data |
| dly_cfg | input | 2 | Extra read delay in cycles (0 to 3) |
| bypass_en | input | 1 | Route this cycle's read or write to the bypass register |
| rd_data | output | 32 | Returned read word |
| rd_valid | output | 1 | rd_data holds a completed read |
| wl_en | output | 1 | Wordline strobe, first pipeline cycle |
| sa_en | output | 1 | Sense strobe, second pipeline cycle |

## Verification
On every cycle, the embedded properties check the strobe ordering: wordline follows each issued read, and sense follows wordline. For each of the four delay settings, they also check that rd_valid appears exactly 2+D cycles after rd_en. The bench's scenarios are the only place data correctness is shown. These include full-bank write and read sweeps at each delay, write-then-read hazards in both orders, the reset value of the bypass register, the isolation of the array from bypass writes, and interleaved bypass and array reads.

// File: rtl/pipe_sram_rd.sv
module pipe_sram_rd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int XDLY_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [XDLY_W-1:0] dly_cfg,
  input  logic              bypass_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              wl_en,
  output logic              sa_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NSTG  = 1 << XDLY_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] byp_q;
  logic              s1_vld, s1_byp;
  logic [ADDR_W-1:0] s1_addr;
  logic [NSTG-1:0]   stg_vld;
  logic [DATA_W-1:0] stg_dat [NSTG];
  logic [DATA_W-1:0] sense_word;

  always_ff @(posedge clk)
    if (wr_en && !bypass_en) mem[addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  byp_q <= '0;
    else if (wr_en && bypass_en) byp_q <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_byp  <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_vld <= rd_en;
      if (rd_en) begin
        s1_byp  <= bypass_en;
        s1_addr <= addr;
      end
    end

  assign sense_word = s1_byp ? byp_q : mem[s1_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stg_vld <= '0;
      for (int i = 0; i < NSTG; i++) stg_dat[i] <= '0;
    end else begin
      stg_vld <= {stg_vld[NSTG-2:0], s1_vld};
      if (s1_vld) stg_dat[0] <= sense_word;
      for (int i = 1; i < NSTG; i++) stg_dat[i] <= stg_dat[i-1];
    end

  assign wl_en    = s1_vld;
  assign sa_en    = stg_vld[0];
  assign rd_valid = stg_vld[dly_cfg];
  assign rd_data  = stg_dat[dly_cfg];

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;

  p_wl_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1) |-> (wl_en == $past(rd_en)));

  p_sense_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2) |-> (sa_en == $past(wl_en)));

  p_lat_d0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && dly_cfg == 0) |-> (rd_valid == $past(rd_en, 2)));

  p_lat_d1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && dly_cfg == 1) |-> (rd_valid == $past(rd_en, 3)));

  p_lat_d2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && dly_cfg == 2) |-> (rd_valid == $past(rd_en, 4)));

  p_lat_d3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && dly_cfg == 3) |-> (rd_valid == $past(rd_en, 5)));

  p_byp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !$past(wr_en && bypass_en)) |-> $stable(byp_q));
endmodule

// File: tb/tb_pipe_sram_rd.sv
`timescale 1ns/1ps
module tb_pipe_sram_rd;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, rd_en, wr_en, bypass_en;
  logic [7:0]  addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  dly_cfg;
  logic        rd_valid, wl_en, sa_en;

  pipe_sram_rd dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .dly_cfg(dly_cfg), .bypass_en(bypass_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .wl_en(wl_en), .sa_en(sa_en)
  );

  int checks = 0, fails = 0, cur = 0;
  bit done = 1'b0;
  logic [31:0] mem_m [256];
  logic [31:0] byp_m = 32'h0;
  bit          ev [16];
  bit          ew [16];
  bit          es [16];
  logic [31:0] ed [16];
  string       et [16];

  function automatic logic [31:0] pat(int a, int p);
    return 32'h9E3779B9 * (a + 1) + p * 32'h01000193;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit re, bit we, bit by, logic [7:0] a, logic [31:0] wd, string tag);
    int s, t;
    s = cur % 16;
    chk("R2 wordline", {31'b0, wl_en}, {31'b0, ew[s]});
    chk("R2 sense", {31'b0, sa_en}, {31'b0, es[s]});
    chk("R3 valid", {31'b0, rd_valid}, {31'b0, ev[s]});
    if (ev[s]) chk({et[s], " data"}, rd_data, ed[s]);
    ev[s] = 1'b0; ew[s] = 1'b0; es[s] = 1'b0;
    rd_en = re; wr_en = we; bypass_en = by; addr = a; wr_data = wd;
    if (we) begin
      if (by) byp_m = wd;
      else    mem_m[a] = wd;
    end
    if (re) begin
      t = (cur + 2 + int'(dly_cfg)) % 16;
      ev[t] = 1'b1;
      ed[t] = by ? byp_m : mem_m[a];
      et[t] = tag;
      ew[(cur + 1) % 16] = 1'b1;
      es[(cur + 2) % 16] = 1'b1;
    end
    cur++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h0, 32'h0, "R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; bypass_en = 1'b0;
    addr = 8'h0; wr_data = 32'h0; dly_cfg = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", {31'b0, rd_valid}, 32'h0);
    chk("R1 wordline in reset", {31'b0, wl_en}, 32'h0);
    chk("R1 sense in reset", {31'b0, sa_en}, 32'h0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 8'h0, 32'h0, "R1 bypass reset");
    idle(6);

    for (int p = 0; p < 4; p++) begin
      dly_cfg = 2'(p);
      for (int a = 0; a < 256; a++) step(1'b0, 1'b1, 1'b0, 8'(a), pat(a, p), "R9");
      for (int a = 0; a < 256; a++) step(1'b1, 1'b0, 1'b0, 8'(a), 32'h0, p == 0 ? "R4" : "R3");
      idle(6);
    end

    dly_cfg = 2'd1;
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 1'b0, 8'(k * 37), pat(k, 11), "R5");
      step(1'b1, 1'b0, 1'b0, 8'(k * 37), 32'h0, "R5");
      step(1'b1, 1'b1, 1'b0, 8'(k * 37), pat(k, 12), "R5");
    end
    idle(6);

    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, 1'b0, 8'(k * 29 + 3), 32'h0, "R6");
      step(1'b0, 1'b1, 1'b0, 8'(k * 29 + 3), pat(k, 13), "R6");
      step(1'b1, 1'b0, 1'b0, 8'(k * 29 + 3), 32'h0, "R6");
    end
    idle(6);

    for (int d = 0; d < 4; d++) begin
      dly_cfg = 2'(d);
      step(1'b0, 1'b1, 1'b1, 8'h11, pat(d, 21), "R7");
      step(1'b1, 1'b0, 1'b1, 8'h42, 32'h0, "R8");
      step(1'b1, 1'b0, 1'b0, 8'h11, 32'h0, "R7 array intact");
      idle(6);
    end

    dly_cfg = 2'd2;
    for (int i = 0; i < 32; i++)
      step(1'b1, (i % 3) == 0, (i % 2) == 1, 8'(i), pat(i, 31), "R8 interleave");
    idle(6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule